// File: doc/BRIEF.md
# Sectioned Address Router with Interleaving

This block takes a 32-bit system address and decides which of two external memory interfaces should serve it. It also works out the address that the chosen controller sees. Software programs a small bank of section descriptors, one 32-bit word each. Every descriptor gives a section of the system map a base, a size, a routing mask, an interleave code and a controller-side base.

For each request the block finds the section that holds the address. A section can send all of its traffic to one interface. It can also split its traffic between both interfaces at a coded byte granularity. When it splits, the interface-select bit is squeezed out of the local address, so each controller sees a dense range. The result is registered and leaves through a valid/ready output port. An address that no section covers comes back with a no-match flag and no interface selected.

Top module: `secmap_top`

## Requirements
- R1: A descriptor word is written through `cfgWe`/`cfgIdx`/`cfgData` and applies to any request accepted in the next cycle or later. Its fields are: bits 31-24 system base MSB, bits 22-20 size code, bits 19-18 interleave code, bits 9-8 target mask, bits 7-0 controller base MSB. Bits 23, 17-16 and 15-10 are ignored.
- R2: A section spans 16 MB shifted left by its size code (3 is 128 MB, 6 is 1 GB). It starts at the base MSB shifted left by 24. An address matches when it lies in that span and the target mask is nonzero. A mask of 0 makes the section inactive.
- R3: Without interleaving, mask 1 gives `rspSel` = 01 (interface 0) and mask 2 gives `rspSel` = 10 (interface 1). Mask 3 with interleave code 0 gives 01.
- R4: With mask 3 and a nonzero interleave code c, the granularity is 64 << c bytes (code 2 is 256 B). System address bit 6+c selects the interface: 0 gives `rspSel` = 01 and 1 gives 10.
- R5: In interleaved mode, the offset bit at position 6+c is removed and the offset bits above it move down by one.
- R6: `rspLocalAddr` is the offset within the section, after compaction where R5 applies, plus the controller base MSB shifted left by 24, modulo 2^32.
- R7: When several sections match, the lowest-numbered one decides the result.
- R8: An address that matches no section gives `rspNoMatch` = 1, `rspSel` = 00 and `rspLocalAddr` = 0.
- R9: `reqReady` is high when the output register is empty or `rspReady` is high. An accepted request shows up on the outputs with `rspValid` in the following cycle. While `rspValid` is high and `rspReady` is low, the outputs hold steady.
- R10: After reset `rspValid` is 0 and every descriptor is zero, so every section is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Descriptor write strobe |
| cfgIdx | input | 2 | Descriptor index to write |
| cfgData | input | 32 | Descriptor word |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqAddr | input | 32 | System address |
| rspValid | output | 1 | Result register holds a result |
| rspReady | input | 1 | Downstream takes the result |
| rspSel | output | 2 | One-hot interface select, bit 0 interface 0, bit 1 interface 1 |
| rspLocalAddr | output | 32 | Controller-side address |
| rspNoMatch | output | 1 | No active section covers the address |

## Verification
On every cycle the assertions check the shape of each result. At most one interface is selected. A no-match result selects none, and a matched result selects one. An accepted request always yields a valid result, and a stalled result does not change. Whether the chosen interface, the rebased address and the winning section are correct depends on the descriptor contents. Only the bench's scenarios can show that: addresses at section edges, both values of the interleave bit, overlapping sections, disabling a section by rewriting it, and backpressure.

// File: rtl/secmap_pkg.sv
package secmap_pkg;
  localparam int ADDR_W    = 32;
  localparam int MSB_SHIFT = 24;
  localparam int GRAN_BASE = 6;

  typedef struct packed {
    logic [7:0] baseMsb;
    logic [2:0] sizeCode;
    logic [1:0] ilCode;
    logic [1:0] mask;
    logic [7:0] ctrlMsb;
  } secDesc_t;

  typedef struct packed {
    logic loadRsp;
    logic clearRsp;
  } ctrlStrobe_t;

  function automatic secDesc_t decodeDesc(input logic [31:0] w);
    secDesc_t d;
    d.baseMsb  = w[31:24];
    d.sizeCode = w[22:20];
    d.ilCode   = w[19:18];
    d.mask     = w[9:8];
    d.ctrlMsb  = w[7:0];
    return d;
  endfunction
endpackage

// File: rtl/secmap_ctrl.sv
module secmap_ctrl
  import secmap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rspReady,
  output logic        reqReady,
  output logic        rspValid,
  output ctrlStrobe_t strobes
);
  logic accept;

  assign reqReady = !rspValid || rspReady;
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobes.loadRsp  = accept;
    strobes.clearRsp = rspReady && !accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
    end else if (strobes.loadRsp) begin
      rspValid <= 1'b1;
    end else if (strobes.clearRsp) begin
      rspValid <= 1'b0;
    end
  end
endmodule

// File: rtl/secmap_dp.sv
module secmap_dp
  import secmap_pkg::*;
#(
  parameter int NUM_SEC = 4,
  localparam int IDX_W  = $clog2(NUM_SEC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  ctrlStrobe_t       strobes,
  output logic [1:0]        rspSel,
  output logic [ADDR_W-1:0] rspLocalAddr,
  output logic              rspNoMatch
);
  logic [31:0]       descWord [NUM_SEC];
  secDesc_t          desc     [NUM_SEC];
  logic [ADDR_W-1:0] offset   [NUM_SEC];
  logic [NUM_SEC-1:0] hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEC; i++) descWord[i] <= '0;
    end else if (cfgWe) begin
      descWord[cfgIdx] <= cfgData;
    end
  end

  for (genvar g = 0; g < NUM_SEC; g++) begin : gSec
    logic [ADDR_W:0] diff;
    logic [ADDR_W:0] spanBytes;
    logic [5:0]      spanShift;
    assign desc[g]    = decodeDesc(descWord[g]);
    assign spanShift  = 6'(MSB_SHIFT) + {3'b0, desc[g].sizeCode};
    assign spanBytes  = (ADDR_W+1)'(1) << spanShift;
    assign diff       = {1'b0, reqAddr} - {1'b0, desc[g].baseMsb, {MSB_SHIFT{1'b0}}};
    assign offset[g]  = diff[ADDR_W-1:0];
    assign hit[g]     = !diff[ADDR_W] && (diff < spanBytes) && (desc[g].mask != 2'b00);
  end

  logic [IDX_W-1:0]  winIdx;
  logic              anyHit;
  secDesc_t          winDesc;
  logic [ADDR_W-1:0] winOff;
  logic [4:0]        granPos;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] compact;
  logic [1:0]        nextSel;
  logic [ADDR_W-1:0] nextLocal;

  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_SEC - 1; i >= 0; i--) begin
      if (hit[i]) begin
        winIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  always_comb begin
    winDesc = desc[winIdx];
    winOff  = offset[winIdx];
    granPos = 5'(GRAN_BASE) + {3'b0, winDesc.ilCode};
    lowMask = (ADDR_W'(1) << granPos) - ADDR_W'(1);
    if (winDesc.mask == 2'b11 && winDesc.ilCode != 2'b00) begin
      nextSel = reqAddr[granPos] ? 2'b10 : 2'b01;
      compact = ((winOff >> (granPos + 5'd1)) << granPos) | (winOff & lowMask);
    end else begin
      nextSel = (winDesc.mask == 2'b10) ? 2'b10 : 2'b01;
      compact = winOff;
    end
    nextLocal = compact + {winDesc.ctrlMsb, {MSB_SHIFT{1'b0}}};
    if (!anyHit) begin
      nextSel   = 2'b00;
      nextLocal = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspSel       <= '0;
      rspLocalAddr <= '0;
      rspNoMatch   <= 1'b0;
    end else if (strobes.loadRsp) begin
      rspSel       <= nextSel;
      rspLocalAddr <= nextLocal;
      rspNoMatch   <= !anyHit;
    end
  end
endmodule

// File: rtl/secmap_top.sv
module secmap_top
  import secmap_pkg::*;
#(
  parameter int NUM_SEC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [1:0]  cfgIdx,
  input  logic [31:0] cfgData,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  output logic        rspValid,
  input  logic        rspReady,
  output logic [1:0]  rspSel,
  output logic [31:0] rspLocalAddr,
  output logic        rspNoMatch
);
  ctrlStrobe_t strobes;

  secmap_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobes  (strobes)
  );

  secmap_dp #(.NUM_SEC(NUM_SEC)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWe        (cfgWe),
    .cfgIdx       (cfgIdx),
    .cfgData      (cfgData),
    .reqAddr      (reqAddr),
    .strobes      (strobes),
    .rspSel       (rspSel),
    .rspLocalAddr (rspLocalAddr),
    .rspNoMatch   (rspNoMatch)
  );
endmodule

// File: rtl/secmap_chk.sv
module secmap_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        rspValid,
  input logic        rspReady,
  input logic [1:0]  rspSel,
  input logic [31:0] rspLocalAddr,
  input logic        rspNoMatch
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot0(rspSel)); // R4
  AST_NOMATCH_NOSEL: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspNoMatch) |-> (rspSel == 2'b00 && rspLocalAddr == 32'h0)); // R8
  AST_MATCH_HAS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspNoMatch) |-> ($countones(rspSel) == 1)); // R3
  AST_ACCEPT_YIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspSel) && $stable(rspLocalAddr)
                                 && $stable(rspNoMatch))); // R9
endmodule

bind secmap_top secmap_chk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .rspValid     (rspValid),
  .rspReady     (rspReady),
  .rspSel       (rspSel),
  .rspLocalAddr (rspLocalAddr),
  .rspNoMatch   (rspNoMatch)
);

// File: tb/sim_secmap_top.sv
module sim_secmap_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [1:0]  rspSel;
  logic [31:0] rspLocalAddr;
  logic        rspNoMatch;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  secmap_top u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspReady(rspReady), .rspSel(rspSel),
    .rspLocalAddr(rspLocalAddr), .rspNoMatch(rspNoMatch)
  );

  // {addr, sel, noMatch, local}
  localparam int NVEC = 13;
  localparam logic [66:0] VECS [NVEC] = '{
    {32'h8000_0000, 2'b01, 1'b0, 32'h0000_0000},
    {32'h8000_0100, 2'b10, 1'b0, 32'h0000_0000},
    {32'h8000_0345, 2'b10, 1'b0, 32'h0000_0145},
    {32'hBFFF_FFFF, 2'b10, 1'b0, 32'h1FFF_FFFF},
    {32'hC000_0000, 2'b01, 1'b0, 32'h2000_0000},
    {32'hC7FF_FFFF, 2'b01, 1'b0, 32'h27FF_FFFF},
    {32'hC800_0000, 2'b00, 1'b1, 32'h0000_0000},
    {32'h7FFF_FFFF, 2'b00, 1'b1, 32'h0000_0000},
    {32'h10AB_CDEF, 2'b10, 1'b0, 32'h05AB_CDEF},
    {32'h0800_0080, 2'b10, 1'b0, 32'h4000_0000},
    {32'h0800_01FF, 2'b10, 1'b0, 32'h4000_00FF},
    {32'h09FF_FF7F, 2'b01, 1'b0, 32'h40FF_FFFF},
    {32'h0A00_0000, 2'b00, 1'b1, 32'h0000_0000}
  };

  function automatic string vecTag(input int i);
    case (i)
      0, 1, 2, 3: return "R4 R5 R6";
      4, 5:       return "R2 R3 R6";
      6, 7, 12:   return "R2 R8";
      8:          return "R3 R6";
      default:    return "R4 R5 R6";
    endcase
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic checkRsp(input string tag, input logic [1:0] expSel,
                          input logic expNm, input logic [31:0] expLocal);
    checks++;
    if (rspValid !== 1'b1 || rspSel !== expSel || rspNoMatch !== expNm ||
        rspLocalAddr !== expLocal) begin
      failures++;
      $display("FAIL %s: got v=%b sel=%b nm=%b local=%h, expected v=1 sel=%b nm=%b local=%h",
               tag, rspValid, rspSel, rspNoMatch, rspLocalAddr, expSel, expNm, expLocal);
    end
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic writeDesc(input logic [1:0] idx, input logic [31:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgData = w;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendReq(input logic [31:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checkBit("R10 rspValid after reset", rspValid, 1'b0);
    checkBit("R9 reqReady when empty", reqReady, 1'b1);
    rstN = 1'b1;
    // R10: all descriptors zero -> inactive
    sendReq(32'h0000_0000);
    checkRsp("R10 R2 inactive zero descriptor", 2'b00, 1'b1, 32'h0);

    // R1: program layout; reserved bits 23 and 17-16 set in word 1 must be ignored
    writeDesc(2'd0, 32'h8068_0300);
    writeDesc(2'd1, 32'hC0B3_0120);
    writeDesc(2'd2, 32'h1000_0205);
    writeDesc(2'd3, 32'h0814_0340);

    for (int i = 0; i < NVEC; i++) begin
      sendReq(VECS[i][66:35]);
      checkRsp(vecTag(i), VECS[i][34:33], VECS[i][32], VECS[i][31:0]);
    end

    // R9: backpressure
    @(negedge clk);
    rspReady = 1'b0;
    reqValid = 1'b1; reqAddr = 32'hC000_0010;
    @(negedge clk);
    reqAddr = 32'h1000_0001;
    repeat (2) @(negedge clk);
    checkRsp("R9 held under stall", 2'b01, 1'b0, 32'h2000_0010);
    checkBit("R9 reqReady low under stall", reqReady, 1'b0);
    rspReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp("R9 next after release", 2'b10, 1'b0, 32'h0500_0001);
    @(negedge clk);
    checkBit("R9 valid drops when drained", rspValid, 1'b0);

    // R7: overlap, lowest index wins
    writeDesc(2'd3, 32'h1000_0177);
    sendReq(32'h1000_0010);
    checkRsp("R7 lower section wins", 2'b10, 1'b0, 32'h0500_0010);

    // R1/R2: disable section 2 by mask 0; request right after write uses new value
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 2'd2; cfgData = 32'h1000_0005;
    @(negedge clk);
    cfgWe = 1'b0;
    reqValid = 1'b1; reqAddr = 32'h1000_0010;
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp("R1 R2 write effective next cycle", 2'b01, 1'b0, 32'h7700_0010);

    // R3: mask 3 with interleave code 0 goes to interface 0
    writeDesc(2'd0, 32'h8060_0311);
    sendReq(32'h8000_0100);
    checkRsp("R3 mask3 no interleave", 2'b01, 1'b0, 32'h1100_0100);

    finished = 1;
    summary();
  end
endmodule